// File: doc/BRIEF.md
# Capture/Waveform Timer Channel

A single timer channel built around a 16-bit up-counter that software controls through a small register bank. The counter advances once per clock while it is running. It returns to zero on any of three events: a software trigger, a level on an external sync pin, or the counter reaching the value held in compare register C. A mode bit picks one of two personalities for the same counter.

In capture mode, transitions on a synchronised input pin copy the running count into register A and register B. Each register has its own edge selection. In waveform mode, registers A, B and C become compare points. A match on A raises the first output pin and a match on B raises the second. A match on C lowers both pins, so together with the C-compare reset this gives two PWM waveforms that share one period.

Every event sets a sticky status flag. Reading the status register clears the flags. An interrupt line is driven whenever any flag is set whose enable bit is also set.

Top module: `tmr_chan`

## Requirements
- R1: After reset the count, registers A, B and C, the status flags and the interrupt enables are all zero, and `tioa_out`, `tiob_out` and `irq` are low.
- R2: Writing bit 0 of the control register (offset 0x00) starts counting and writing bit 1 stops it, with bit 1 winning when both are set. While running, the count read at offset 0x10 rises by exactly one per clock. While stopped, it holds.
- R3: When a running count is at 0xFFFF and no reset applies, it wraps to 0 on the next clock and sets status bit 0 (status register at offset 0x20).
- R4: Writing bit 2 of the control register zeroes the count on the next clock, whether the counter is running or stopped.
- R5: When mode bit 5 is set (mode register at offset 0x04), a high level on `sync_in` zeroes the count on the next clock. When mode bit 5 is clear, `sync_in` has no effect.
- R6: When mode bit 4 is set, a running count equal to register C (offset 0x1C) goes to 0 on the next clock, so the count repeats 0..C. In both modes, a running count equal to C sets status bit 5.
- R7: In capture mode (mode bit 7 clear), mode bits [1:0] select the `tioa_in` edge that loads register A (offset 0x14): 0 none, 1 rising, 2 falling, 3 both. The pin passes a two-flop synchroniser, so the value loaded is the count present two clocks after the pin changes. Each load sets status bit 1.
- R8: In capture mode, mode bits [3:2] select the edge that loads register B (offset 0x18), with the same encoding and latency as R7. Each load sets status bit 2.
- R9: In capture mode, software writes to registers A and B have no effect.
- R10: In waveform mode (mode bit 7 set), `tioa_out` goes high the clock after a running count equals A and goes low the clock after it equals C, with C winning. Matches on A and B set status bits 3 and 4. Outside waveform mode, both output pins are low.
- R11: In waveform mode, `tiob_out` goes high the clock after a running count equals B and goes low the clock after it equals C, with C winning when B equals C.
- R12: A bus read of the status register returns the flags and clears them on that clock.
- R13: `irq` is high exactly when some status flag is set and its enable bit, at the same position in the enable register (offset 0x24, bits [5:0]), is also set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status when reading it) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| sync_in | input | 1 | External counter reset, level sensitive |
| tioa_in | input | 1 | Capture input pin (asynchronous) |
| tioa_out | output | 1 | First waveform output |
| tiob_out | output | 1 | Second waveform output |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all four edge selections for A and B together, using complementary settings, and computes each captured value from the count read when the pin was driven plus the two synchroniser clocks. A design that loses a synchroniser stage, or swaps the rising and falling codes, captures a value that is off by one or loads the wrong register. It runs several A/B/C waveform configurations, including A at zero and B equal to C, and predicts each pin cycle by cycle from the previous count. Getting the set/clear priority or the output register stage wrong shows up as a pin that glitches high or is shifted by a clock. The bench also runs the counter through a full 16-bit wrap, sweeps the C-compare period over several values, and checks that software writes to A and B are ignored in capture mode and that `irq` follows enable masking and the clear-on-read of the status register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Register byte offsets
    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_MODE = 8'h04;
    localparam logic [7:0] OFF_CNT  = 8'h10;
    localparam logic [7:0] OFF_RA   = 8'h14;
    localparam logic [7:0] OFF_RB   = 8'h18;
    localparam logic [7:0] OFF_RC   = 8'h1C;
    localparam logic [7:0] OFF_STAT = 8'h20;
    localparam logic [7:0] OFF_IEN  = 8'h24;

    // Control command bits
    localparam int CTL_START = 0;
    localparam int CTL_STOP  = 1;
    localparam int CTL_TRIG  = 2;

    // Status flag positions
    localparam int ST_W    = 6;
    localparam int ST_OVF  = 0;
    localparam int ST_LDA  = 1;
    localparam int ST_LDB  = 2;
    localparam int ST_CMPA = 3;
    localparam int ST_CMPB = 4;
    localparam int ST_CMPC = 5;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_e;

    typedef struct packed {
        logic      wave;
        logic      spare;
        logic      sync_en;
        logic      rc_rst;
        edge_sel_e sel_b;
        edge_sel_e sel_a;
    } mode_t;

    localparam logic [7:0] MODE_MASK = 8'hBF;

    function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
        logic hit;
        unique case (sel)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_ANY:  hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int TOP = STAGES;

    // sh[STAGES-1:0] synchronise, sh[TOP] holds the previous settled value
    logic [TOP:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[TOP-1:0], din};
    end

    always_comb begin
        rise = sh[TOP-1] & ~sh[TOP];
        fall = ~sh[TOP-1] & sh[TOP];
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         sw_clr,
    input  logic         sync_clr,
    input  logic         rc_rst_en,
    input  logic [W-1:0] rc_val,
    output logic [W-1:0] cnt,
    output logic         hit_c,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_TOP = '1;

    logic [W-1:0] cnt_q;
    logic         rc_fold;

    always_comb begin
        hit_c   = run && (cnt_q == rc_val);
        rc_fold = hit_c && rc_rst_en;
        wrap    = run && !sw_clr && !sync_clr && !rc_fold && (cnt_q == CNT_TOP);
    end

    always_ff @(posedge clk) begin
        if (rst)                      cnt_q <= '0;
        else if (sw_clr || sync_clr)  cnt_q <= '0;
        else if (rc_fold)             cnt_q <= '0;
        else if (run)                 cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tmr_wavegen.sv
module tmr_wavegen #(
    parameter int N_OUT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wave_en,
    input  logic [N_OUT-1:0] set_hit,
    input  logic             clr_hit,
    output logic [N_OUT-1:0] pins
);
    logic [N_OUT-1:0] pin_q;

    for (genvar g = 0; g < N_OUT; g++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst || !wave_en) pin_q[g] <= 1'b0;
            else if (clr_hit)    pin_q[g] <= 1'b0;
            else if (set_hit[g]) pin_q[g] <= 1'b1;
        end
    end

    assign pins = pin_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sync_in,
    input  logic              tioa_in,
    output logic              tioa_out,
    output logic              tiob_out,
    output logic              irq
);
    localparam int N_WAVE = 2;

    // Register-select decode
    logic sel_ctrl, sel_mode, sel_ra, sel_rb, sel_rc, sel_stat, sel_ien;
    always_comb begin
        sel_ctrl = bus_addr == ADDR_W'(OFF_CTRL);
        sel_mode = bus_addr == ADDR_W'(OFF_MODE);
        sel_ra   = bus_addr == ADDR_W'(OFF_RA);
        sel_rb   = bus_addr == ADDR_W'(OFF_RB);
        sel_rc   = bus_addr == ADDR_W'(OFF_RC);
        sel_stat = bus_addr == ADDR_W'(OFF_STAT);
        sel_ien  = bus_addr == ADDR_W'(OFF_IEN);
    end

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

    // State
    mode_t            mode_q;
    logic             run_q;
    logic [CNT_W-1:0] ra_q, rb_q, rc_q;
    logic [ST_W-1:0]  status_q, ier_q;

    logic             sw_clr, sync_clr, rc_rst_on, wave_on;
    logic [CNT_W-1:0] cnt;
    logic             hit_c, wrap;
    logic             pin_rise, pin_fall;
    logic             cap_a_ld, cap_b_ld;
    logic             match_a, match_b;
    logic [ST_W-1:0]  events;
    logic [N_WAVE-1:0] wave_pins;

    always_comb begin
        wave_on   = mode_q.wave;
        rc_rst_on = mode_q.rc_rst;
        sw_clr    = bus_wr && sel_ctrl && bus_wdata[CTL_TRIG];
        sync_clr  = sync_in && mode_q.sync_en;
    end

    // Run control: stop wins over start
    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else if (bus_wr && sel_ctrl) begin
            if (bus_wdata[CTL_STOP])       run_q <= 1'b0;
            else if (bus_wdata[CTL_START]) run_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                     mode_q <= '0;
        else if (bus_wr && sel_mode) mode_q <= mode_t'(bus_wdata[7:0] & MODE_MASK);
    end

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (run_q),
        .sw_clr   (sw_clr),
        .sync_clr (sync_clr),
        .rc_rst_en(rc_rst_on),
        .rc_val   (rc_q),
        .cnt      (cnt),
        .hit_c    (hit_c),
        .wrap     (wrap)
    );

    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk (clk),
        .rst (rst),
        .din (tioa_in),
        .rise(pin_rise),
        .fall(pin_fall)
    );

    always_comb begin
        cap_a_ld = !wave_on && edge_hit(mode_q.sel_a, pin_rise, pin_fall);
        cap_b_ld = !wave_on && edge_hit(mode_q.sel_b, pin_rise, pin_fall);
        match_a  = run_q && (cnt == ra_q);
        match_b  = run_q && (cnt == rb_q);
    end

    // A and B: loaded by capture in capture mode, by software in waveform mode
    always_ff @(posedge clk) begin
        if (rst) begin
            ra_q <= '0;
            rb_q <= '0;
        end else begin
            if (cap_a_ld)                          ra_q <= cnt;
            else if (wave_on && bus_wr && sel_ra)  ra_q <= bus_wdata[CNT_W-1:0];
            if (cap_b_ld)                          rb_q <= cnt;
            else if (wave_on && bus_wr && sel_rb)  rb_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                   rc_q <= '0;
        else if (bus_wr && sel_rc) rc_q <= bus_wdata[CNT_W-1:0];
    end

    tmr_wavegen #(.N_OUT(N_WAVE)) u_wave (
        .clk    (clk),
        .rst    (rst),
        .wave_en(wave_on),
        .set_hit({match_b, match_a}),
        .clr_hit(hit_c),
        .pins   (wave_pins)
    );

    assign tioa_out = wave_pins[0];
    assign tiob_out = wave_pins[1];

    // Status flags: read clears, a new event in the same clock survives
    always_comb begin
        events          = '0;
        events[ST_OVF]  = wrap;
        events[ST_LDA]  = cap_a_ld;
        events[ST_LDB]  = cap_b_ld;
        events[ST_CMPA] = wave_on && match_a;
        events[ST_CMPB] = wave_on && match_b;
        events[ST_CMPC] = hit_c;
    end

    always_ff @(posedge clk) begin
        if (rst)                        status_q <= '0;
        else if (bus_rd && sel_stat)    status_q <= events;
        else                            status_q <= status_q | events;
    end

    always_ff @(posedge clk) begin
        if (rst)                    ier_q <= '0;
        else if (bus_wr && sel_ien) ier_q <= bus_wdata[ST_W-1:0];
    end

    assign irq = |(status_q & ier_q);

    always_comb begin
        bus_rdata = '0;
        if (sel_mode)      bus_rdata = DATA_W'(mode_q);
        else if (sel_ra)   bus_rdata = DATA_W'(ra_q);
        else if (sel_rb)   bus_rdata = DATA_W'(rb_q);
        else if (sel_rc)   bus_rdata = DATA_W'(rc_q);
        else if (sel_stat) bus_rdata = DATA_W'(status_q);
        else if (sel_ien)  bus_rdata = DATA_W'(ier_q);
        else if (bus_addr == ADDR_W'(OFF_CNT)) bus_rdata = DATA_W'(cnt);
    end
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic             run_q,
    input logic             sw_clr,
    input logic             sync_clr,
    input logic             rc_rst_on,
    input logic [CNT_W-1:0] rc_q,
    input logic             wave_on,
    input logic             cap_a_ld,
    input logic [CNT_W-1:0] ra_q,
    input logic [ST_W-1:0]  status_q,
    input logic [ST_W-1:0]  ier_q,
    input logic             tioa_out,
    input logic             tiob_out,
    input logic             irq
);
    localparam logic [CNT_W-1:0] CNT_ALL = '1;

    logic plain_step;
    assign plain_step = run_q && !sw_clr && !sync_clr && !(rc_rst_on && cnt == rc_q);

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        plain_step |=> CNT_W'(cnt - $past(cnt)) == CNT_W'(1));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !sw_clr && !sync_clr) |=> $stable(cnt));

    assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (plain_step && cnt == CNT_ALL) |=> (cnt == '0) && status_q[ST_OVF]);

    assert_trig_zero_R4: assert property (@(posedge clk) disable iff (rst)
        sw_clr |=> cnt == '0);

    assert_cap_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (!wave_on && !cap_a_ld) |=> $stable(ra_q));

    assert_pins_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !wave_on |=> (!tioa_out && !tiob_out));

    assert_irq_masked_R13: assert property (@(posedge clk) disable iff (rst)
        (ier_q == '0) |-> !irq);

    assert_irq_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        (status_q == '0) |-> !irq);
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tmr_chan_tb_top.sv
`timescale 1ns/1ps
module tmr_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        sync_in, tioa_in;
    logic        tioa_out, tiob_out, irq;

    always #2.5 clk = ~clk;

    tmr_chan dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sync_in(sync_in), .tioa_in(tioa_in),
        .tioa_out(tioa_out), .tiob_out(tiob_out), .irq(irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Each task starts at a falling edge and returns one clock later at the next one
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_pin(input logic [7:0] a, input logic pin, output logic [31:0] d);
        tioa_in = pin;
        rd(a, d);
    endtask

    function automatic logic wave_exp(int i, int set_at, int clr_at);
        int prev;
        if (i == 0) return 1'b0;
        prev = (i - 1) % (clr_at + 1);
        return (prev >= set_at) && (prev < clr_at);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, w;
        logic [31:0] exp_a, exp_b;
        int ca[3];
        int cb[3];
        int cc[3];
        ca = '{2, 1, 0};
        cb = '{4, 3, 5};
        cc = '{6, 4, 5};

        rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        sync_in = 0; tioa_in = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h10, v); check("R1 count", v, 0);
        rd(8'h20, v); check("R1 status", v, 0);
        rd(8'h14, v); check("R1 reg A", v, 0);
        rd(8'h1C, v); check("R1 reg C", v, 0);
        rd(8'h24, v); check("R1 enables", v, 0);
        check("R1 pins", {29'd0, tioa_out, tiob_out, irq}, 0);

        // R2 counting, then stop
        wr(8'h00, 32'h1);
        for (int i = 0; i < 5; i++) begin
            rd(8'h10, v); check("R2 count step", v, i);
        end
        wr(8'h00, 32'h3);
        rd(8'h10, v); rd(8'h10, w); check("R2 stop wins and holds", w, v);

        // R4 trigger while stopped
        wr(8'h00, 32'h4);
        rd(8'h10, v); check("R4 trigger zeroes", v, 0);
        rd(8'h10, v); check("R4 still stopped", v, 0);

        // R5 sync enabled, then disabled
        wr(8'h04, 32'h20);
        wr(8'h00, 32'h1);
        repeat (5) @(negedge clk);
        sync_in = 1'b1; @(negedge clk); sync_in = 1'b0;
        rd(8'h10, v); check("R5 sync zeroes", v, 0);
        rd(8'h10, v); check("R5 resumes", v, 1);
        wr(8'h04, 32'h0);
        rd(8'h10, v);
        sync_in = 1'b1; @(negedge clk); sync_in = 1'b0;
        rd(8'h10, w); check("R5 sync ignored", w, v + 2);

        // R3 full wrap
        wr(8'h00, 32'h5);
        rd(8'h20, v); check("R3 no overflow yet", v & 32'h1, 0);
        repeat (65534) @(negedge clk);
        rd(8'h10, v); check("R3 top value", v, 32'hFFFF);
        rd(8'h20, v); check("R3 overflow flag", v & 32'h1, 1);
        rd(8'h10, v); check("R3 wrapped", v, 1);

        // R6 C-compare reset period sweep
        wr(8'h00, 32'h2);
        foreach (cc[k]) begin
            wr(8'h1C, cc[k] + 1);
            wr(8'h04, 32'h10);
            rd(8'h20, v);
            wr(8'h00, 32'h5);
            for (int i = 0; i < 2 * (cc[k] + 2); i++) begin
                rd(8'h10, v); check("R6 period", v, i % (cc[k] + 2));
            end
            wr(8'h00, 32'h2);
            rd(8'h20, v); check("R6 compare C flag", v & 32'h20, 32'h20);
        end

        // R7 / R8 capture edge sweep, complementary selections
        exp_a = 0; exp_b = 0;
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h5);
        for (int e = 0; e < 4; e++) begin
            wr(8'h04, e | ((3 - e) << 2));
            rd(8'h20, v);
            rd_pin(8'h10, 1'b1, v);
            repeat (4) @(negedge clk);
            if (e & 1)       exp_a = v + 2;
            if ((3 - e) & 1) exp_b = v + 2;
            rd(8'h14, w); check("R7 rising A", w, exp_a);
            rd(8'h18, w); check("R8 rising B", w, exp_b);
            rd_pin(8'h10, 1'b0, v);
            repeat (4) @(negedge clk);
            if (e & 2)       exp_a = v + 2;
            if ((3 - e) & 2) exp_b = v + 2;
            rd(8'h14, w); check("R7 falling A", w, exp_a);
            rd(8'h18, w); check("R8 falling B", w, exp_b);
            rd(8'h20, v);
            check("R7 load A flag", v[1], e != 0);
            check("R8 load B flag", v[2], (3 - e) != 0);
        end

        // R9 software writes ignored in capture mode
        wr(8'h14, 32'h1234);
        rd(8'h14, v); check("R9 A unchanged", v, exp_a);
        wr(8'h18, 32'h4321);
        rd(8'h18, v); check("R9 B unchanged", v, exp_b);

        // R10 / R11 waveform sweeps
        foreach (ca[k]) begin
            wr(8'h00, 32'h2);
            wr(8'h04, 32'h0);
            wr(8'h04, 32'h90);
            wr(8'h14, ca[k]);
            wr(8'h18, cb[k]);
            wr(8'h1C, cc[k]);
            rd(8'h20, v);
            wr(8'h00, 32'h5);
            for (int i = 0; i < 3 * (cc[k] + 1); i++) begin
                check("R10 tioa_out", tioa_out, wave_exp(i, ca[k], cc[k]));
                check("R11 tiob_out", tiob_out, wave_exp(i, cb[k], cc[k]));
                @(negedge clk);
            end
            wr(8'h00, 32'h2);
            rd(8'h20, v); check("R10 compare flags", v & 32'h38, 32'h38);
        end

        // R12 clear on read
        rd(8'h20, v); check("R12 cleared", v, 0);

        // R13 interrupt masking
        wr(8'h00, 32'h1);
        repeat (10) @(negedge clk);
        wr(8'h00, 32'h2);
        check("R13 no enables", irq, 0);
        wr(8'h24, 32'h01);
        check("R13 other flag enabled", irq, 0);
        wr(8'h24, 32'h20);
        check("R13 enabled flag", irq, 1);
        rd(8'h24, v); check("R13 enable readback", v, 32'h20);
        rd(8'h20, v); check("R12 read returns flags", v & 32'h20, 32'h20);
        check("R13 cleared by read", irq, 0);

        // R10 leaving waveform mode drops the pins
        wr(8'h04, 32'h0);
        check("R10 idle pins", {30'd0, tioa_out, tiob_out}, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule